// File: doc/BRIEF.md
# Branch Trace Record Writer

This block turns control-flow events into records in a memory-resident trace buffer. Each reported taken branch, interrupt or exception is checked against an enable flag, a facility-availability input, the current special operating mode and the room left in the buffer. An accepted event is queued, and a writer streams the record to memory as three 64-bit words through a simple request/ready port. A committed index pointer advances by one record after each completed write.

Software programs a base pointer, a limit pointer and the enable flag through single-cycle write strobes. While the system-management mode input is high, no events are accepted and the enable flag is held clear. A machine-check pulse also clears the flag. In both cases software must set the flag again before recording resumes. Records that were accepted before recording was disabled are still written out.

Top module: `trace_rec_writer`

## Requirements
- R1: While enabled, an event with kind 0 (taken branch), 1 (interrupt) or 2 (exception) produces one record; an event with kind 3 produces no memory write.
- R2: A control write of 1 sets the enable flag only when `unavail` is low; while `unavail` is high, such a write leaves `trc_en` clear.
- R3: A base write loads the index pointer only when no record is queued or being written; otherwise it is ignored. An event in the same cycle as an accepted base write is dropped.
- R4: While `smm_act` is high, no event is accepted, `trc_en` is clear from the next cycle, and control writes cannot set it; it stays clear after the mode ends.
- R5: A `mce` pulse clears `trc_en` on the next edge, overriding a control write in the same cycle; the flag stays clear until written to 1 again.
- R6: A record is written as word 0 = source address at index+0, word 1 = target address at index+8, and word 2 = flags at index+16, with the kind in bits 1:0 and zeros above. Address and data are held while `mem_ready` is low.
- R7: The index pointer advances by 24 bytes when the third word of a record is accepted.
- R8: An event is accepted only if the reserved pointer plus 24 does not exceed the programmed limit. The limit is 0 after reset. A refused event is dropped without setting the overflow flag.
- R9: Events that find the DEPTH-entry queue full are dropped, and `ovf` is set and stays set until reset.
- R10: Records queued before a machine-check pulse are still written out afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_en_wr | input | 1 | Strobe writing the enable flag |
| ctl_en_val | input | 1 | Enable value written |
| unavail | input | 1 | High when the trace facility is not available |
| ctl_base_wr | input | 1 | Strobe writing the base pointer |
| ctl_base_val | input | MA_W | Base byte address of the save area |
| ctl_lim_wr | input | 1 | Strobe writing the limit pointer |
| ctl_lim_val | input | MA_W | Limit byte address |
| smm_act | input | 1 | System-management mode active |
| mce | input | 1 | Machine-check event pulse |
| ev_valid | input | 1 | Event report valid this cycle |
| ev_kind | input | 2 | Event kind code |
| ev_from | input | VA_W | Source address of the event |
| ev_to | input | VA_W | Target address of the event |
| mem_req | output | 1 | Memory write request |
| mem_ready | input | 1 | Memory accepts the current word |
| mem_addr | output | MA_W | Byte address of the word |
| mem_data | output | 64 | Word data |
| trc_en | output | 1 | Enable flag |
| ovf | output | 1 | Sticky queue overflow |
| cur_index | output | MA_W | Committed index pointer |

## Verification
Record emission is swept over all four kind codes with varied address patterns. The memory side is driven three ways: always ready, ready every third cycle, and ready held low while events arrive back to back. The first pattern separates word order and addressing errors. The second exposes data that changes while a request is stalled. The third pins the exact point at which the queue overflows. Further phases separate the gating causes (unavailable facility, system-management mode, machine check, limit reached, base write while busy), because each one leaves a distinct count of written records and a distinct index value.

// File: rtl/trw_pkg.sv
package trw_pkg;
  localparam int WORD_W     = 64;
  localparam int KIND_W     = 2;
  localparam int REC_WORDS  = 3;
  localparam int WORD_BYTES = 8;
  localparam int REC_BYTES  = REC_WORDS * WORD_BYTES;

  typedef enum logic [KIND_W-1:0] {
    EV_BRANCH = 2'd0,
    EV_INTR   = 2'd1,
    EV_EXCEPT = 2'd2,
    EV_NONE   = 2'd3
  } ev_kind_e;

  // flags word of a record: kind in the low bits, zeros above
  function automatic logic [WORD_W-1:0] flags_word(input logic [KIND_W-1:0] k);
    return {{(WORD_W-KIND_W){1'b0}}, k};
  endfunction

  // byte offset of word w inside a record
  function automatic logic [WORD_W-1:0] word_offset(input logic [1:0] w);
    return WORD_W'(w) * WORD_W'(WORD_BYTES);
  endfunction
endpackage

// File: rtl/trw_fifo.sv
module trw_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wr_data,
  input  logic         pop,
  output logic [W-1:0] rd_data,
  output logic         full,
  output logic         empty
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign rd_data = mem_q[rp_q];

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wp_q <= ptr_inc(wp_q);
      if (pop)  rp_q <= ptr_inc(rp_q);
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/trw_ctrl.sv
module trw_ctrl
  import trw_pkg::*;
#(
  parameter int MA_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_en_wr,
  input  logic            ctl_en_val,
  input  logic            unavail,
  input  logic            ctl_base_wr,
  input  logic [MA_W-1:0] ctl_base_val,
  input  logic            ctl_lim_wr,
  input  logic [MA_W-1:0] ctl_lim_val,
  input  logic            smm_act,
  input  logic            mce,
  input  logic            ev_valid,
  input  logic [KIND_W-1:0] ev_kind,
  input  logic            fifo_full,
  input  logic            outstanding,
  output logic            en_q,
  output logic            push,
  output logic            ovf_q,
  output logic            base_load
);
  localparam logic [MA_W-1:0] STEP = MA_W'(REC_BYTES);

  logic [MA_W-1:0] alloc_q, limit_q;
  logic            kill, room, want, overflow_hit, kind_ok;

  // room check done one bit wider so the sum cannot wrap
  function automatic logic fits(input logic [MA_W-1:0] a, input logic [MA_W-1:0] lim);
    return ({1'b0, a} + {1'b0, STEP}) <= {1'b0, lim};
  endfunction

  assign kill         = mce | smm_act;
  assign base_load    = ctl_base_wr & ~outstanding;
  assign room         = fits(alloc_q, limit_q);
  assign kind_ok      = (ev_kind_e'(ev_kind) != EV_NONE);
  assign want         = ev_valid & en_q & ~kill & kind_ok & room & ~base_load;
  assign push         = want & ~fifo_full;
  assign overflow_hit = want & fifo_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      ovf_q   <= 1'b0;
      alloc_q <= '0;
      limit_q <= '0;
    end else begin
      if (kill)           en_q <= 1'b0;
      else if (ctl_en_wr) en_q <= ctl_en_val & ~unavail;

      if (overflow_hit) ovf_q <= 1'b1;

      if (base_load) alloc_q <= ctl_base_val;
      else if (push) alloc_q <= alloc_q + STEP;

      if (ctl_lim_wr) limit_q <= ctl_lim_val;
    end
  end
endmodule

// File: rtl/trw_emit.sv
module trw_emit
  import trw_pkg::*;
#(
  parameter int VA_W = 64,
  parameter int MA_W = 32,
  localparam int REC_W = 2 * VA_W + KIND_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [REC_W-1:0]  head,
  input  logic              empty,
  input  logic              mem_ready,
  input  logic              base_load,
  input  logic [MA_W-1:0]   base_val,
  output logic              pop,
  output logic              busy,
  output logic              mem_req,
  output logic [MA_W-1:0]   mem_addr,
  output logic [WORD_W-1:0] mem_data,
  output logic              rec_done,
  output logic [MA_W-1:0]   idx
);
  localparam logic [MA_W-1:0] STEP = MA_W'(REC_BYTES);
  localparam logic [1:0]      LAST = 2'(REC_WORDS - 1);

  logic             busy_q;
  logic [1:0]       wsel_q;
  logic [REC_W-1:0] rec_q;
  logic [MA_W-1:0]  idx_q;

  assign busy     = busy_q;
  assign pop      = ~busy_q & ~empty;
  assign rec_done = busy_q & mem_ready & (wsel_q == LAST);
  assign mem_req  = busy_q;
  assign mem_addr = idx_q + MA_W'(word_offset(wsel_q));
  assign idx      = idx_q;

  always_comb begin
    case (wsel_q)
      2'd0:    mem_data = WORD_W'(rec_q[REC_W-1 -: VA_W]);
      2'd1:    mem_data = WORD_W'(rec_q[KIND_W +: VA_W]);
      default: mem_data = flags_word(rec_q[KIND_W-1:0]);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      wsel_q <= '0;
      rec_q  <= '0;
      idx_q  <= '0;
    end else begin
      if (base_load) idx_q <= base_val;
      if (pop) begin
        rec_q  <= head;
        busy_q <= 1'b1;
        wsel_q <= '0;
      end else if (busy_q && mem_ready) begin
        if (wsel_q == LAST) begin
          busy_q <= 1'b0;
          idx_q  <= idx_q + STEP;
        end else begin
          wsel_q <= wsel_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/trace_rec_writer.sv
module trace_rec_writer
  import trw_pkg::*;
#(
  parameter int VA_W  = 64,
  parameter int MA_W  = 32,
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_en_wr,
  input  logic              ctl_en_val,
  input  logic              unavail,
  input  logic              ctl_base_wr,
  input  logic [MA_W-1:0]   ctl_base_val,
  input  logic              ctl_lim_wr,
  input  logic [MA_W-1:0]   ctl_lim_val,
  input  logic              smm_act,
  input  logic              mce,
  input  logic              ev_valid,
  input  logic [1:0]        ev_kind,
  input  logic [VA_W-1:0]   ev_from,
  input  logic [VA_W-1:0]   ev_to,
  output logic              mem_req,
  input  logic              mem_ready,
  output logic [MA_W-1:0]   mem_addr,
  output logic [63:0]       mem_data,
  output logic              trc_en,
  output logic              ovf,
  output logic [MA_W-1:0]   cur_index
);
  localparam int REC_W = 2 * VA_W + KIND_W;

  // named internal events, observed by the checker
  logic push_w, pop_w, rec_done_w, base_load_w;
  logic fifo_full_w, fifo_empty_w, busy_w;
  logic [REC_W-1:0] head_w;

  trw_ctrl #(.MA_W(MA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctl_en_wr(ctl_en_wr), .ctl_en_val(ctl_en_val), .unavail(unavail),
    .ctl_base_wr(ctl_base_wr), .ctl_base_val(ctl_base_val),
    .ctl_lim_wr(ctl_lim_wr), .ctl_lim_val(ctl_lim_val),
    .smm_act(smm_act), .mce(mce),
    .ev_valid(ev_valid), .ev_kind(ev_kind),
    .fifo_full(fifo_full_w), .outstanding(busy_w | ~fifo_empty_w),
    .en_q(trc_en), .push(push_w), .ovf_q(ovf), .base_load(base_load_w)
  );

  trw_fifo #(.W(REC_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(push_w), .wr_data({ev_from, ev_to, ev_kind}),
    .pop(pop_w), .rd_data(head_w),
    .full(fifo_full_w), .empty(fifo_empty_w)
  );

  trw_emit #(.VA_W(VA_W), .MA_W(MA_W)) u_emit (
    .clk(clk), .rst_n(rst_n),
    .head(head_w), .empty(fifo_empty_w), .mem_ready(mem_ready),
    .base_load(base_load_w), .base_val(ctl_base_val),
    .pop(pop_w), .busy(busy_w),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_data(mem_data),
    .rec_done(rec_done_w), .idx(cur_index)
  );
endmodule

// File: rtl/trw_chk.sv
module trw_chk #(
  parameter int MA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            unavail,
  input logic            smm_act,
  input logic            mce,
  input logic            trc_en,
  input logic            ovf,
  input logic            mem_req,
  input logic            mem_ready,
  input logic [MA_W-1:0] mem_addr,
  input logic [63:0]     mem_data,
  input logic            push,
  input logic            rec_done,
  input logic [MA_W-1:0] cur_index
);
  AST_EN_NEEDS_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trc_en) |-> $past(!unavail)); // R2
  AST_SMM_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    smm_act |-> !push); // R4
  AST_SMM_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    smm_act |=> !trc_en); // R4
  AST_MCE_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
    mce |=> !trc_en); // R5
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_data)); // R6
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rec_done |=> cur_index == $past(cur_index) + MA_W'(24)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R9
endmodule

bind trace_rec_writer trw_chk #(.MA_W(MA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .unavail(unavail), .smm_act(smm_act), .mce(mce),
  .trc_en(trc_en), .ovf(ovf), .mem_req(mem_req), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .push(push_w),
  .rec_done(rec_done_w), .cur_index(cur_index)
);

// File: tb/test_trace_rec_writer.sv
module test_trace_rec_writer;
  localparam int VA_W = 64, MA_W = 32, DEPTH = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic ctl_en_wr = 0, ctl_en_val = 0, unavail = 0, ctl_base_wr = 0, ctl_lim_wr = 0;
  logic [MA_W-1:0] ctl_base_val = '0, ctl_lim_val = '0;
  logic smm_act = 0, mce = 0, ev_valid = 0, mem_ready = 0;
  logic [1:0] ev_kind = '0;
  logic [VA_W-1:0] ev_from = '0, ev_to = '0;
  logic mem_req, trc_en, ovf;
  logic [MA_W-1:0] mem_addr, cur_index;
  logic [63:0] mem_data;

  trace_rec_writer #(.VA_W(VA_W), .MA_W(MA_W), .DEPTH(DEPTH)) i_trace_rec_writer (
    .clk(clk), .rst_n(rst_n), .ctl_en_wr(ctl_en_wr), .ctl_en_val(ctl_en_val),
    .unavail(unavail), .ctl_base_wr(ctl_base_wr), .ctl_base_val(ctl_base_val),
    .ctl_lim_wr(ctl_lim_wr), .ctl_lim_val(ctl_lim_val), .smm_act(smm_act),
    .mce(mce), .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_from(ev_from),
    .ev_to(ev_to), .mem_req(mem_req), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .trc_en(trc_en), .ovf(ovf), .cur_index(cur_index)
  );

  int checks = 0, fails = 0;
  logic [MA_W-1:0] exp_addr [0:511];
  logic [63:0]     exp_data [0:511];
  int ewr = 0, erd = 0;
  logic [MA_W-1:0] model_idx = '0;

  // ready pattern: 0 held low, 1 always high, 2 every third cycle
  int rdy_mode = 1, cyc = 0;
  always @(posedge clk) begin
    cyc++;
    #1 mem_ready = (rdy_mode == 1) || (rdy_mode == 2 && cyc % 3 == 0);
  end

  // word monitor (R6): every accepted word must match the next expected one
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ready) begin
      checks++;
      if (erd >= ewr) begin
        fails++;
        $display("FAIL R1 unexpected write addr=%h data=%h, expected no write", mem_addr, mem_data);
      end else begin
        if (mem_addr !== exp_addr[erd] || mem_data !== exp_data[erd]) begin
          fails++;
          $display("FAIL R6 word %0d addr=%h data=%h, expected addr=%h data=%h",
                   erd, mem_addr, mem_data, exp_addr[erd], exp_data[erd]);
        end
        erd++;
      end
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired, actual running, expected finished");
    summary();
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic expect_rec(input logic [1:0] k, input logic [63:0] f, input logic [63:0] t);
    exp_addr[ewr] = model_idx;       exp_data[ewr] = f;                ewr++;
    exp_addr[ewr] = model_idx + 8;   exp_data[ewr] = t;                ewr++;
    exp_addr[ewr] = model_idx + 16;  exp_data[ewr] = {62'd0, k};       ewr++;
    model_idx = model_idx + 24;
  endtask

  task automatic send(input logic [1:0] k, input logic [63:0] f, input logic [63:0] t);
    ev_valid = 1; ev_kind = k; ev_from = f; ev_to = t;
    step(1);
    ev_valid = 0;
  endtask

  task automatic ctl_en(input logic v);
    ctl_en_wr = 1; ctl_en_val = v; step(1); ctl_en_wr = 0;
  endtask

  task automatic set_base(input logic [MA_W-1:0] b);
    ctl_base_wr = 1; ctl_base_val = b; step(1); ctl_base_wr = 0;
  endtask

  task automatic set_lim(input logic [MA_W-1:0] l);
    ctl_lim_wr = 1; ctl_lim_val = l; step(1); ctl_lim_wr = 0;
  endtask

  task automatic drain(input string tag);
    step(60);
    chk(tag, 64'(erd), 64'(ewr));
  endtask

  function automatic logic [63:0] mk_from(input int k, input int p);
    return 64'hA5A5_0000_0000_1000 ^ (64'(k) << 40) ^ (64'(p) << 12) ^ 64'(p * 8);
  endfunction

  task automatic sweep(input int gap, input int salt);
    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < 4; p++) begin
        logic [63:0] f, t;
        f = mk_from(k, p + salt);
        t = ~f ^ 64'(k * 3);
        if (k != 3) expect_rec(2'(k), f, t); // R1: kind 3 writes nothing
        send(2'(k), f, t);
        step(gap);
      end
    end
  endtask

  initial begin
    step(3);
    rst_n = 1;
    step(1);
    // reset state
    chk("R5 reset trc_en", 64'(trc_en), 0);
    chk("R6 reset mem_req", 64'(mem_req), 0);
    chk("R9 reset ovf", 64'(ovf), 0);
    chk("R7 reset index", 64'(cur_index), 0);

    set_base(32'h1000);
    set_lim(32'h1_0000);
    model_idx = 32'h1000;
    chk("R3 base load idle", 64'(cur_index), 64'h1000);

    // R2: unavailable facility
    unavail = 1;
    ctl_en(1);
    chk("R2 enable refused while unavailable", 64'(trc_en), 0);
    send(0, 64'h11, 64'h22);
    drain("R2 no record while disabled");
    unavail = 0;
    ctl_en(1);
    chk("R2 enable accepted when available", 64'(trc_en), 1);

    // R1/R6/R7: sweep with ready always high, then ready every third cycle
    rdy_mode = 1;
    sweep(4, 0);
    drain("R1 record count ready-high sweep");
    chk("R7 index after sweep", 64'(cur_index), 64'(model_idx));
    rdy_mode = 2;
    sweep(10, 7);
    drain("R1 record count stalled sweep");
    chk("R7 index after stalled sweep", 64'(cur_index), 64'(model_idx));

    // R9: back-to-back burst with memory stalled
    rdy_mode = 0;
    step(1);
    chk("R9 ovf clear before burst", 64'(ovf), 0);
    for (int i = 0; i < DEPTH + 3; i++) begin
      logic [63:0] f;
      f = 64'hBEEF_0000_0000_0000 + 64'(i * 16);
      if (i <= DEPTH) expect_rec(2'(i % 3), f, ~f);
      ev_valid = 1; ev_kind = 2'(i % 3); ev_from = f; ev_to = ~f;
      step(1);
    end
    ev_valid = 0;
    chk("R9 ovf set after burst", 64'(ovf), 1);
    rdy_mode = 1;
    drain("R9 only queued records written");
    chk("R9 ovf sticky", 64'(ovf), 1);

    // R8: limit of two records
    set_base(32'h2000);
    model_idx = 32'h2000;
    set_lim(32'h2000 + 48);
    for (int i = 0; i < 3; i++) begin
      if (i < 2) expect_rec(2'd1, 64'(i + 5), 64'(i + 9));
      send(2'd1, 64'(i + 5), 64'(i + 9));
      step(6);
    end
    drain("R8 writes stop at limit");
    chk("R8 index at limit", 64'(cur_index), 64'h2030);
    set_lim(32'h1_0000);

    // R3: base write ignored while a record is outstanding
    rdy_mode = 0;
    expect_rec(2'd2, 64'h77, 64'h88);
    send(2'd2, 64'h77, 64'h88);
    step(2);
    set_base(32'h3000);
    chk("R3 base write ignored while busy", 64'(cur_index), 64'h2030);
    rdy_mode = 1;
    drain("R3 pending record written");
    chk("R3 index continues from old base", 64'(cur_index), 64'h2048);
    set_base(32'h3000);
    model_idx = 32'h3000;
    chk("R3 base load after idle", 64'(cur_index), 64'h3000);

    // R5/R10: machine check
    rdy_mode = 0;
    expect_rec(2'd0, 64'hC0, 64'hC1);
    send(2'd0, 64'hC0, 64'hC1);
    step(2);
    mce = 1; ctl_en_wr = 1; ctl_en_val = 1;
    step(1);
    mce = 0; ctl_en_wr = 0;
    chk("R5 machine check clears enable", 64'(trc_en), 0);
    send(2'd0, 64'hD0, 64'hD1);
    step(2);
    chk("R5 enable stays clear", 64'(trc_en), 0);
    rdy_mode = 1;
    drain("R10 queued record written after machine check");
    ctl_en(1);
    chk("R5 enable restored by write", 64'(trc_en), 1);

    // R4: system-management mode
    smm_act = 1;
    step(1);
    chk("R4 mode clears enable", 64'(trc_en), 0);
    ctl_en(1);
    chk("R4 enable write refused in mode", 64'(trc_en), 0);
    send(2'd1, 64'hE0, 64'hE1);
    smm_act = 0;
    step(2);
    chk("R4 enable stays clear after mode", 64'(trc_en), 0);
    drain("R4 no record from mode");
    chk("R4 index unchanged", 64'(cur_index), 64'(model_idx));

    summary();
  end
endmodule